// File: doc/BRIEF.md
# Core Idle-State Power Sequencer

This block sits beside one processor core and walks it between normal running and four idle states. From lightest to deepest they are doze, nap, sleep and deep winkle; each deeper state saves more energy and takes longer to wake from. Every idle state is reached by applying an ordered chain of power-saving steps. Leaving it removes the same steps in the opposite order. The seven steps, in entry order, are: stop the fetch/dispatch clock, stop the execution-unit clocks, select the reduced core frequency, purge the caches and TLB, stop the clock of the whole core and its caches, lower the supply to retention voltage, and request the power gate.

Doze applies the first step only. Nap applies the first three, so the caches keep their clocks, stay coherent and need no purge on wake. Sleep applies the first six. Deep winkle applies all seven. The purge, the voltage change and the power gate are level handshakes with outside logic, and the sequencer holds on such a step until the matching acknowledge arrives. A wake event that comes while an entry is still under way cancels it and unwinds whatever was already applied. The state code reports only completed transitions, and a busy flag covers every transition in progress.

Top module: `core_idle_sequencer`

## Requirements
- R1: After reset all three clock enables are 1, freqDivSel, purgeReq, retentionReq and powerGateReq are 0, stateCode is 0 (running) and busy is 0.
- R2: The encoding of reqState and of stateCode is 0 run, 1 doze, 2 nap, 3 sleep, 4 deep winkle. While the core runs and is not busy, values 0 and 5 to 7 on reqState start nothing.
- R3: Doze drops only fetchClkEn. busy goes high one cycle after the request and stateCode becomes 1 one cycle later. A wake in doze restores fetchClkEn, sets stateCode to 0 and clears busy one cycle after the wake is sampled.
- R4: Nap drops fetchClkEn and execClkEn and sets freqDivSel, and never raises purgeReq. stateCode becomes 2 four cycles after the request. A wake from nap completes three cycles after it is sampled.
- R5: Sleep raises purgeReq and holds it until purgeAck is sampled high. Only then does coreClkEn fall, with purgeReq dropping in the same cycle. retentionReq rises one cycle after coreClkEn falls.
- R6: retentionReq is never high while coreClkEn is high. On wake from sleep, retentionReq drops first, and coreClkEn and the other clock steps return only after vrAck has been seen low.
- R7: Deep winkle raises powerGateReq only after vrAck has been seen high, and powerGateReq is never high without retentionReq. On wake, powerGateReq drops first, and retentionReq stays high until pwrGood is seen high.
- R8: A wake during an entry cancels it: the applied steps are removed in reverse order, one per cycle when no acknowledge is pending, and the block returns to running with stateCode still 0.
- R9: stateCode changes only in the cycle a transition completes. busy is high from the first step of a transition until the cycle that completes it.
- R10: In an idle state, reqState is ignored and only a wake leaves. While running, a wake is ignored, and a wake that is high together with a request blocks the request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqState | input | 3 | Requested idle state (1 doze, 2 nap, 3 sleep, 4 deep winkle) |
| wakeEvt | input | 1 | Wake event; leaves an idle state or cancels an entry |
| purgeAck | input | 1 | Cache/TLB purge finished |
| vrAck | input | 1 | Regulator status: 1 at retention voltage, 0 at nominal |
| pwrGood | input | 1 | Power switch status: 1 when the core is powered |
| fetchClkEn | output | 1 | Fetch/dispatch clock enable |
| execClkEn | output | 1 | Execution-unit clock enable |
| coreClkEn | output | 1 | Whole core and cache clock enable |
| freqDivSel | output | 1 | Select the reduced core frequency |
| purgeReq | output | 1 | Cache/TLB purge request |
| retentionReq | output | 1 | Request retention voltage |
| powerGateReq | output | 1 | Request the core power gate |
| stateCode | output | 3 | Last completed state, same encoding as reqState |
| busy | output | 1 | A transition is in progress |

## Verification
The hardest case to reach is a cancelled entry that stops partway through a handshake step: the wake has to land while purgeReq waits for its acknowledge, or while retentionReq or powerGateReq is raised but not yet answered. The bench's purge, regulator and power-switch models have adjustable latency and a hold switch, so the sequence can be frozen on that step and the wake applied there. A sweep over every idle state and several handshake latencies checks the final output pattern against a per-state step count, while a monitor checks the voltage and clock ordering on every cycle.

// File: rtl/idle_seq_pkg.sv
package idle_seq_pkg;

  localparam int unsigned NUM_STEPS = 7;
  localparam int unsigned CODE_W    = 3;
  localparam int unsigned POS_W     = $clog2(NUM_STEPS + 1);

  typedef enum logic [CODE_W-1:0] {
    PS_RUN    = 3'd0,
    PS_DOZE   = 3'd1,
    PS_NAP    = 3'd2,
    PS_SLEEP  = 3'd3,
    PS_WINKLE = 3'd4
  } pwrState_e;

  // step positions, in entry order
  localparam logic [POS_W-1:0] STEP_FETCH  = POS_W'(1);
  localparam logic [POS_W-1:0] STEP_EXEC   = POS_W'(2);
  localparam logic [POS_W-1:0] STEP_FREQ   = POS_W'(3);
  localparam logic [POS_W-1:0] STEP_PURGE  = POS_W'(4);
  localparam logic [POS_W-1:0] STEP_CORE   = POS_W'(5);
  localparam logic [POS_W-1:0] STEP_VOLT   = POS_W'(6);
  localparam logic [POS_W-1:0] STEP_GATE   = POS_W'(7);

  typedef struct packed {
    logic [NUM_STEPS:1]  setStep;
    logic [NUM_STEPS:1]  clrStep;
    logic                loadCode;
    logic [CODE_W-1:0]   codeVal;
  } seqStrobe_t;

  // number of steps applied to reach a given state
  function automatic logic [POS_W-1:0] depthOf(input logic [CODE_W-1:0] st);
    case (st)
      PS_DOZE:   depthOf = STEP_FETCH;
      PS_NAP:    depthOf = STEP_FREQ;
      PS_SLEEP:  depthOf = STEP_VOLT;
      PS_WINKLE: depthOf = STEP_GATE;
      default:   depthOf = '0;
    endcase
  endfunction

  function automatic logic [NUM_STEPS:1] stepMask(input logic [POS_W-1:0] p);
    logic [NUM_STEPS:1] m;
    m = '0;
    for (int i = 1; i <= int'(NUM_STEPS); i++) begin
      if (p == POS_W'(i)) m[i] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/idle_seq_ctrl.sv
module idle_seq_ctrl
  import idle_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] reqState,
  input  logic              wakeEvt,
  input  logic              purgeAck,
  input  logic              vrAck,
  input  logic              pwrGood,
  input  logic [CODE_W-1:0] curCode,
  output seqStrobe_t        strobe,
  output logic              busy
);

  typedef enum logic [1:0] {PH_REST, PH_ENTER, PH_EXIT} phase_e;

  phase_e            phase, phaseNext;
  logic [POS_W-1:0]  pos, posNext;
  logic [POS_W-1:0]  tgtDepth, tgtDepthNext;
  logic [CODE_W-1:0] tgtCode, tgtCodeNext;

  logic reqValid;
  logic entryDone;
  logic undoDone;
  logic doUndo;

  assign reqValid = (reqState == PS_DOZE) || (reqState == PS_NAP) ||
                    (reqState == PS_SLEEP) || (reqState == PS_WINKLE);

  // completion condition of the step currently being applied
  always_comb begin
    case (pos)
      STEP_PURGE: entryDone = purgeAck;
      STEP_VOLT:  entryDone = vrAck;
      STEP_GATE:  entryDone = !pwrGood;
      default:    entryDone = 1'b1;
    endcase
  end

  // completion condition of the step currently being removed
  always_comb begin
    case (pos)
      STEP_VOLT: undoDone = !vrAck;
      STEP_GATE: undoDone = pwrGood;
      default:   undoDone = 1'b1;
    endcase
  end

  assign doUndo = (phase == PH_EXIT) ||
                  ((phase == PH_ENTER) && wakeEvt) ||
                  ((phase == PH_REST) && (curCode != PS_RUN) && wakeEvt);

  always_comb begin
    strobe       = '0;
    phaseNext    = phase;
    posNext      = pos;
    tgtDepthNext = tgtDepth;
    tgtCodeNext  = tgtCode;

    if (doUndo) begin
      phaseNext      = PH_EXIT;
      strobe.clrStep = stepMask(pos);
      if (undoDone) begin
        if (pos <= STEP_FETCH) begin
          phaseNext       = PH_REST;
          posNext         = '0;
          strobe.loadCode = 1'b1;
          strobe.codeVal  = PS_RUN;
        end else begin
          posNext = pos - POS_W'(1);
        end
      end
    end else if (phase == PH_REST) begin
      if ((curCode == PS_RUN) && !wakeEvt && reqValid) begin
        phaseNext      = PH_ENTER;
        posNext        = STEP_FETCH;
        strobe.setStep = stepMask(STEP_FETCH);
        tgtDepthNext   = depthOf(reqState);
        tgtCodeNext    = reqState;
      end
    end else if (phase == PH_ENTER) begin
      if (entryDone) begin
        if (pos == tgtDepth) begin
          phaseNext       = PH_REST;
          strobe.loadCode = 1'b1;
          strobe.codeVal  = tgtCode;
        end else begin
          posNext        = pos + POS_W'(1);
          strobe.setStep = stepMask(pos + POS_W'(1));
          if (pos == STEP_PURGE) strobe.clrStep = stepMask(STEP_PURGE);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_REST;
      pos      <= '0;
      tgtDepth <= '0;
      tgtCode  <= PS_RUN;
    end else begin
      phase    <= phaseNext;
      pos      <= posNext;
      tgtDepth <= tgtDepthNext;
      tgtCode  <= tgtCodeNext;
    end
  end

  assign busy = (phase != PH_REST);

endmodule

// File: rtl/idle_seq_datapath.sv
module idle_seq_datapath
  import idle_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  output logic              fetchClkEn,
  output logic              execClkEn,
  output logic              coreClkEn,
  output logic              freqDivSel,
  output logic              purgeReq,
  output logic              retentionReq,
  output logic              powerGateReq,
  output logic [CODE_W-1:0] stateCode
);

  logic [NUM_STEPS:1] stepQ;
  logic [CODE_W-1:0]  codeQ;

  for (genvar i = 1; i <= int'(NUM_STEPS); i++) begin : g_step
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 stepQ[i] <= 1'b0;
      else if (strobe.setStep[i]) stepQ[i] <= 1'b1;
      else if (strobe.clrStep[i]) stepQ[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                codeQ <= PS_RUN;
    else if (strobe.loadCode) codeQ <= strobe.codeVal;
  end

  assign fetchClkEn   = !stepQ[STEP_FETCH];
  assign execClkEn    = !stepQ[STEP_EXEC];
  assign freqDivSel   =  stepQ[STEP_FREQ];
  assign purgeReq     =  stepQ[STEP_PURGE];
  assign coreClkEn    = !stepQ[STEP_CORE];
  assign retentionReq =  stepQ[STEP_VOLT];
  assign powerGateReq =  stepQ[STEP_GATE];
  assign stateCode    = codeQ;

endmodule

// File: rtl/core_idle_sequencer.sv
module core_idle_sequencer
  import idle_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] reqState,
  input  logic              wakeEvt,
  input  logic              purgeAck,
  input  logic              vrAck,
  input  logic              pwrGood,
  output logic              fetchClkEn,
  output logic              execClkEn,
  output logic              coreClkEn,
  output logic              freqDivSel,
  output logic              purgeReq,
  output logic              retentionReq,
  output logic              powerGateReq,
  output logic [CODE_W-1:0] stateCode,
  output logic              busy
);

  seqStrobe_t strobe;

  idle_seq_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .reqState (reqState),
    .wakeEvt  (wakeEvt),
    .purgeAck (purgeAck),
    .vrAck    (vrAck),
    .pwrGood  (pwrGood),
    .curCode  (stateCode),
    .strobe   (strobe),
    .busy     (busy)
  );

  idle_seq_datapath dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .fetchClkEn   (fetchClkEn),
    .execClkEn    (execClkEn),
    .coreClkEn    (coreClkEn),
    .freqDivSel   (freqDivSel),
    .purgeReq     (purgeReq),
    .retentionReq (retentionReq),
    .powerGateReq (powerGateReq),
    .stateCode    (stateCode)
  );

endmodule

// File: rtl/core_idle_sequencer_chk.sv
module core_idle_sequencer_chk (
  input logic       clk,
  input logic       rstN,
  input logic       wakeEvt,
  input logic       purgeAck,
  input logic       fetchClkEn,
  input logic       execClkEn,
  input logic       coreClkEn,
  input logic       retentionReq,
  input logic       powerGateReq,
  input logic [2:0] stateCode,
  input logic       busy
);

  // R3: wake from doze completes in one cycle
  a_r3_doze_wake: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && stateCode == 3'd1 && wakeEvt) |=> (fetchClkEn && !busy && stateCode == 3'd0));

  // R4: execution clocks are never off while fetch runs
  a_r4_exec_under_fetch: assert property (@(posedge clk) disable iff (!rstN)
    !execClkEn |-> !fetchClkEn);

  // R5: core clock only gated after the purge was acknowledged
  a_r5_purge_before_core: assert property (@(posedge clk) disable iff (!rstN)
    $fell(coreClkEn) |-> $past(purgeAck));

  // R6: no retention voltage while the core clock runs
  a_r6_clock_off_for_retention: assert property (@(posedge clk) disable iff (!rstN)
    coreClkEn |-> !retentionReq);

  // R7: power gate only at retention voltage
  a_r7_gate_needs_retention: assert property (@(posedge clk) disable iff (!rstN)
    powerGateReq |-> retentionReq);

  // R9: code frozen during a transition
  a_r9_code_stable_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> $stable(stateCode));

  // R10: idle without wake stays put
  a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && stateCode != 3'd0 && !wakeEvt) |=> (!busy && $stable(stateCode)));

endmodule

bind core_idle_sequencer core_idle_sequencer_chk chk_i (.*);

// File: tb/core_idle_sequencer_tb_top.sv
module core_idle_sequencer_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] reqState = 3'd0;
  logic       wakeEvt = 1'b0;
  logic       purgeAck, vrAck, pwrGood;
  logic       fetchClkEn, execClkEn, coreClkEn, freqDivSel;
  logic       purgeReq, retentionReq, powerGateReq, busy;
  logic [2:0] stateCode;

  int testCnt = 0;
  int failCnt = 0;
  int monFail = 0;
  int cycleCnt = 0;
  int purgeLat = 1, vrLat = 1, pgLat = 1;
  bit holdPurge = 1'b0;
  bit purgeSeen = 1'b0;
  int pCnt = 0, vCnt = 0, gCnt = 0;
  logic [2:0] prevCode = 3'd0;

  always #4 clk = ~clk;

  core_idle_sequencer dut_i (
    .clk(clk), .rstN(rstN), .reqState(reqState), .wakeEvt(wakeEvt),
    .purgeAck(purgeAck), .vrAck(vrAck), .pwrGood(pwrGood),
    .fetchClkEn(fetchClkEn), .execClkEn(execClkEn), .coreClkEn(coreClkEn),
    .freqDivSel(freqDivSel), .purgeReq(purgeReq), .retentionReq(retentionReq),
    .powerGateReq(powerGateReq), .stateCode(stateCode), .busy(busy)
  );

  // environment models: purge engine, regulator, power switch
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      purgeAck <= 1'b0; vrAck <= 1'b0; pwrGood <= 1'b1;
      pCnt <= 0; vCnt <= 0; gCnt <= 0;
    end else begin
      if (purgeReq && !holdPurge) begin
        pCnt <= pCnt + 1;
        purgeAck <= (pCnt + 1 >= purgeLat);
      end else begin
        if (!purgeReq) pCnt <= 0;
        purgeAck <= 1'b0;
      end
      if (retentionReq != vrAck) begin
        if (vCnt + 1 >= vrLat) begin vrAck <= retentionReq; vCnt <= 0; end
        else vCnt <= vCnt + 1;
      end else vCnt <= 0;
      if (powerGateReq == pwrGood) begin
        if (gCnt + 1 >= pgLat) begin pwrGood <= !powerGateReq; gCnt <= 0; end
        else gCnt <= gCnt + 1;
      end else gCnt <= 0;
    end
  end

  // ordering monitor (R5, R6, R7, R9)
  always @(negedge clk) begin
    if (rstN) begin
      if (coreClkEn && (retentionReq || vrAck)) monFail++;
      if (powerGateReq && !retentionReq) monFail++;
      if (!retentionReq && !pwrGood) monFail++;
      if (!execClkEn && fetchClkEn) monFail++;
      if (busy && stateCode != prevCode) monFail++;
      if (purgeReq) purgeSeen = 1'b1;
      prevCode <= stateCode;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int depthFor(input int s);
    return (s == 1) ? 1 : (s == 2) ? 3 : (s == 3) ? 6 : (s == 4) ? 7 : 0;
  endfunction

  function automatic int outVec();
    return {powerGateReq, retentionReq, !coreClkEn, purgeReq,
            freqDivSel, !execClkEn, !fetchClkEn};
  endfunction

  function automatic int expVec(input int d);
    return ((1 << d) - 1) & ~32'h8;
  endfunction

  task automatic waitIdle();
    for (int i = 0; i < 500 && busy; i++) tick(1);
  endtask

  task automatic enter(input int s);
    reqState = 3'(s);
    tick(1);
    reqState = 3'd0;
    waitIdle();
  endtask

  task automatic wake();
    wakeEvt = 1'b1;
    tick(1);
    wakeEvt = 1'b0;
    waitIdle();
  endtask

  always @(posedge clk) begin
    cycleCnt++;
    if (cycleCnt == 150000) begin
      failCnt++; testCnt++;
      $display("FAIL watchdog actual=%0d expected=0", cycleCnt);
      $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  initial begin
    tick(3);
    // R1 reset state
    check(outVec() == 0 && fetchClkEn && execClkEn && coreClkEn, "R1 outputs in reset", outVec(), 0);
    check(stateCode == 0 && !busy, "R1 code/busy in reset", stateCode, 0);
    rstN = 1'b1;
    tick(2);
    check(outVec() == 0 && stateCode == 0 && !busy, "R1 after release", outVec(), 0);

    // R2 invalid requests while running
    for (int v = 5; v <= 7; v++) begin
      reqState = 3'(v); tick(3); reqState = 3'd0;
      check(!busy && stateCode == 0 && outVec() == 0, "R2 invalid code ignored", outVec(), 0);
    end

    // R3 doze exact timing
    reqState = 3'd1; tick(1); reqState = 3'd0;
    check(busy && !fetchClkEn && execClkEn && stateCode == 0, "R3 doze first step", outVec(), 1);
    tick(1);
    check(!busy && stateCode == 1 && outVec() == 1, "R3 doze reached", stateCode, 1);
    wakeEvt = 1'b1; tick(1); wakeEvt = 1'b0;
    check(fetchClkEn && !busy && stateCode == 0, "R3 doze wake one cycle", stateCode, 0);

    // R4 nap timing, no purge
    purgeSeen = 1'b0;
    reqState = 3'd2; tick(1); reqState = 3'd0;
    tick(2);
    check(busy && stateCode == 0, "R4 nap busy, code unchanged (R9)", stateCode, 0);
    tick(1);
    check(!busy && stateCode == 2 && outVec() == expVec(3), "R4 nap after 4 cycles", outVec(), expVec(3));
    // R10 request in idle ignored
    reqState = 3'd3; tick(5); reqState = 3'd0;
    check(!busy && stateCode == 2 && coreClkEn && !purgeReq, "R10 request in nap ignored", stateCode, 2);
    wakeEvt = 1'b1; tick(1); wakeEvt = 1'b0;
    tick(1);
    check(busy && stateCode == 2, "R4 nap wake in progress", stateCode, 2);
    tick(1);
    check(!busy && stateCode == 0 && outVec() == 0, "R4 nap wake three cycles", outVec(), 0);
    check(!purgeSeen, "R4 nap never purges", int'(purgeSeen), 0);

    // R10 wake in run blocks request
    wakeEvt = 1'b1; reqState = 3'd2; tick(3); wakeEvt = 1'b0; reqState = 3'd0;
    check(!busy && stateCode == 0 && execClkEn, "R10 wake in run ignored", stateCode, 0);

    // sweep states and latencies (R4 R5 R6 R7)
    for (int s = 1; s <= 4; s++) begin
      for (int lat = 1; lat <= 3; lat++) begin
        purgeLat = lat; vrLat = lat; pgLat = lat;
        enter(s);
        check(stateCode == 3'(s) && outVec() == expVec(depthFor(s)),
              "R5 R7 entry pattern", outVec(), expVec(depthFor(s)));
        wake();
        check(stateCode == 0 && outVec() == 0 && pwrGood && !vrAck,
              "R6 R7 exit restores run", outVec(), 0);
      end
    end

    // R8 cancel while purge pending
    purgeLat = 1; vrLat = 1; pgLat = 1;
    holdPurge = 1'b1;
    reqState = 3'd3; tick(1); reqState = 3'd0;
    for (int i = 0; i < 50 && !purgeReq; i++) tick(1);
    tick(3);
    check(purgeReq && busy && coreClkEn && stateCode == 0, "R8 held at purge", outVec(), 15);
    wakeEvt = 1'b1; tick(1); wakeEvt = 1'b0;
    tick(2);
    check(busy, "R8 purge unwind in progress", int'(busy), 1);
    tick(1);
    check(!busy && stateCode == 0 && outVec() == 0, "R8 purge cancel restores run", outVec(), 0);
    holdPurge = 1'b0;

    // R8 cancel while voltage pending
    vrLat = 20;
    reqState = 3'd3; tick(1); reqState = 3'd0;
    for (int i = 0; i < 50 && !retentionReq; i++) tick(1);
    wakeEvt = 1'b1; tick(1); wakeEvt = 1'b0;
    tick(4);
    check(busy && stateCode == 0, "R8 voltage unwind in progress", stateCode, 0);
    tick(1);
    check(!busy && stateCode == 0 && outVec() == 0, "R8 voltage cancel in six cycles", outVec(), 0);

    // R8 cancel while power gate pending
    vrLat = 1; pgLat = 20;
    reqState = 3'd4; tick(1); reqState = 3'd0;
    for (int i = 0; i < 80 && !powerGateReq; i++) tick(1);
    check(powerGateReq && vrAck, "R7 gate after retention ack", int'(vrAck), 1);
    wakeEvt = 1'b1; tick(1); wakeEvt = 1'b0;
    waitIdle();
    check(!busy && stateCode == 0 && outVec() == 0, "R8 gate cancel restores run", outVec(), 0);
    pgLat = 1;

    check(monFail == 0, "R5 R6 R7 R9 ordering monitor", monFail, 0);

    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule